// File: doc/BRIEF.md
# Flash Geometry Query Sequencer

This block runs the common flash interface query on a parallel NOR flash and turns the table it reads into a geometry record. A one-cycle `start` pulse begins a run. Each query byte is fetched with its own three bus accesses: the query-entry command goes out, one read follows, and then the command that restores read-array mode. A run ends with a one-cycle `done` pulse. The result is then held on the status outputs until the next run.

The engine first checks the three signature bytes. It then captures the command-set identifier, the device size, the write-buffer size and the erase-region count. Each region descriptor is unpacked into a block size and a block count. The regions are placed back to back from address zero, so each one gets a start and an end address. The region table is stored inside the block and read through an indexed port.

The chip data width and the number of interleaved chips are parameters. They set the address mapping, the byte lane used for the returned data, and the scale factor applied to all sizes.

Top module: `cfi_geom_engine`

## Requirements
- R1: After reset, `busy`, `done`, `fl_we`, `fl_re`, `qry_fail`, `rgn_clamped`, `rgn_count`, `alg_id`, `dev_size` and `wbuf_size` are all zero.
- R2: Every query byte costs exactly three bus accesses, in this order:
  - a write of command 0x98 to query word 0x55;
  - one cycle later, a read of the byte's offset (read data is taken one cycle after `fl_re`);
  - two cycles after the read, a write of command 0xFF to query word 0x55.
  A run with a good signature and N regions stored therefore makes 7+4N reads and twice as many writes, and ends with the flash in read-array mode.
- R3: With 8-bit chips, the bus address is the offset shifted left by one, and each chip lane carries the command byte. With 16-bit chips, the offset is the bus address, each chip lane carries `{cmd, 8'h00}`, and the returned byte is bits [15:8].
- R4: Offsets 0x10, 0x11 and 0x12 must read 0x51, 0x52 and 0x59 (Q, R, Y). On the first mismatch the run ends with `done` and `qry_fail`=1. No further reads are made, and `rgn_count` and `alg_id` stay zero.
- R5: `alg_id` holds the byte read at offset 0x13.
- R6: `dev_size` = IL * 2^(byte at 0x27) and `wbuf_size` = IL * 2^(byte at 0x2A), where IL is the interleave count. Both are 32-bit.
- R7: The byte at 0x2C is the region count. A value above MAX_RGN is clamped to MAX_RGN and sets `rgn_clamped`. Only the clamped number of descriptors is read.
- R8: Descriptor i sits at offsets 0x2D+4i to 0x30+4i, with the lowest offset holding the least significant byte. The block size is bits[31:16] * 256 * IL, and the block count is bits[15:0] + 1.
- R9: Region 0 starts at 0. Each region's end is its start plus block size times block count, taken modulo 2^32. The next region starts at that end.
- R10: `done` is a single-cycle pulse, one per run, in the cycle after the last access. `busy` is high from the cycle after `start` until `done`, and a `start` during `busy` is ignored.
- R11: For `rd_idx` < `rgn_count`, the read port shows that region's start, end, block size and block count in the same cycle. For any other index it shows zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a query run (pulse) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| qry_fail | output | 1 | Signature mismatch in the last run |
| rgn_clamped | output | 1 | Region count exceeded table capacity |
| alg_id | output | 8 | Command-set identifier |
| dev_size | output | 32 | Device size in bytes |
| wbuf_size | output | 32 | Write-buffer size in bytes |
| rgn_count | output | CNT_W | Number of regions stored |
| rd_idx | input | IDX_W | Region table read index |
| rd_start | output | 32 | Region start address |
| rd_stop | output | 32 | Region end address (exclusive) |
| rd_bsize | output | 32 | Region block size |
| rd_bcount | output | 17 | Region block count |
| fl_addr | output | BUS_AW | Flash bus word address |
| fl_wdata | output | CHIP_W*IL | Flash bus write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | CHIP_W*IL | Flash read data, one cycle after `fl_re` |

## Verification
Two instances run the same table side by side: one built from 16-bit chips and one from two interleaved 8-bit chips. A lane or address mistake would give wrong sizes, or flash-model protocol errors, in only one of them.

Region counts from zero up to one past capacity are swept, along with a count of 255. This exposes an off-by-one in the stop condition or the clamp, which would show up as extra descriptor reads, a wrong `rgn_count`, or a missing warning flag.

Each signature byte is corrupted in turn, to catch an engine that keeps reading after a mismatch. Descriptor fields of 0xFFFF check the 32-bit wrap of the end address. A restart pulse in the middle of a run must not add accesses or a second `done`.

// File: rtl/cfi_geom_pkg.sv
package cfi_geom_pkg;

    localparam logic [7:0] QRY_CMD   = 8'h98;
    localparam logic [7:0] ARR_CMD   = 8'hFF;
    localparam logic [7:0] QRY_WORD  = 8'h55;
    localparam logic [7:0] OFS_SIG   = 8'h10;
    localparam logic [7:0] OFS_ALG   = 8'h13;
    localparam logic [7:0] OFS_DSZ   = 8'h27;
    localparam logic [7:0] OFS_WBS   = 8'h2A;
    localparam logic [7:0] OFS_NRG   = 8'h2C;
    localparam logic [7:0] OFS_RGN0  = 8'h2D;

    typedef enum logic [2:0] {
        PH_SIG, PH_ALG, PH_DSZ, PH_WBS, PH_NRG, PH_RGN
    } phase_t;

    typedef enum logic [2:0] {
        FS_IDLE, FS_ENTER, FS_READ, FS_CAP, FS_EXIT
    } fetch_st_t;

    typedef struct packed {
        logic [31:0] start;
        logic [31:0] stop;
        logic [31:0] bsize;
        logic [16:0] bcount;
    } region_t;

    function automatic logic [7:0] sig_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    return 8'h51;
            2'd1:    return 8'h52;
            default: return 8'h59;
        endcase
    endfunction

endpackage

// File: rtl/cfi_byte_fetch.sv
module cfi_byte_fetch
    import cfi_geom_pkg::*;
#(
    parameter int CHIP_W = 16,
    parameter int IL     = 1,
    parameter int BUS_AW = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req,
    input  logic [7:0]             ofs,
    output logic [BUS_AW-1:0]      fl_addr,
    output logic [CHIP_W*IL-1:0]   fl_wdata,
    output logic                   fl_we,
    output logic                   fl_re,
    input  logic [CHIP_W*IL-1:0]   fl_rdata,
    output logic [7:0]             byte_o,
    output logic                   byte_vld
);
    localparam int BUS_DW = CHIP_W * IL;

    fetch_st_t           st;
    logic [7:0]          byte_r;
    logic [7:0]          lane_byte;
    logic [BUS_AW-1:0]   q_addr;
    logic [BUS_AW-1:0]   o_addr;
    logic [BUS_DW-1:0]   enter_w;
    logic [BUS_DW-1:0]   exit_w;
    logic                unused_rdata;

    assign unused_rdata = ^fl_rdata;

    generate
        if (CHIP_W == 8) begin : g_narrow
            assign q_addr    = BUS_AW'({QRY_WORD, 1'b0});
            assign o_addr    = BUS_AW'({ofs, 1'b0});
            assign lane_byte = fl_rdata[7:0];
            for (genvar k = 0; k < IL; k++) begin : g_lane
                assign enter_w[k*CHIP_W +: CHIP_W] = QRY_CMD;
                assign exit_w[k*CHIP_W +: CHIP_W]  = ARR_CMD;
            end
        end else begin : g_wide
            assign q_addr    = BUS_AW'(QRY_WORD);
            assign o_addr    = BUS_AW'(ofs);
            assign lane_byte = fl_rdata[CHIP_W-1 -: 8];
            for (genvar k = 0; k < IL; k++) begin : g_lane
                assign enter_w[k*CHIP_W +: CHIP_W] = {QRY_CMD, (CHIP_W-8)'(0)};
                assign exit_w[k*CHIP_W +: CHIP_W]  = {ARR_CMD, (CHIP_W-8)'(0)};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= FS_IDLE;
            byte_r <= '0;
        end else begin
            unique case (st)
                FS_IDLE:  if (req) st <= FS_ENTER;
                FS_ENTER: st <= FS_READ;
                FS_READ:  st <= FS_CAP;
                FS_CAP: begin
                    byte_r <= lane_byte;
                    st     <= FS_EXIT;
                end
                FS_EXIT:  st <= FS_IDLE;
                default:  st <= FS_IDLE;
            endcase
        end
    end

    always_comb begin
        fl_we    = (st == FS_ENTER) || (st == FS_EXIT);
        fl_re    = (st == FS_READ);
        fl_addr  = (st == FS_READ) ? o_addr : q_addr;
        fl_wdata = (st == FS_ENTER) ? enter_w : ((st == FS_EXIT) ? exit_w : '0);
        byte_vld = (st == FS_EXIT);
        byte_o   = byte_r;
    end

endmodule

// File: rtl/cfi_region_calc.sv
module cfi_region_calc
    import cfi_geom_pkg::*;
#(
    parameter int IL = 1
) (
    input  logic [31:0] desc,
    input  logic [31:0] base,
    output region_t     rgn
);
    logic [31:0] bsize;
    logic [16:0] bcount;

    always_comb begin
        bsize      = 32'({desc[31:16], 8'h00}) * 32'(IL);
        bcount     = 17'(desc[15:0]) + 17'd1;
        rgn.start  = base;
        rgn.bsize  = bsize;
        rgn.bcount = bcount;
        rgn.stop   = base + bsize * {15'd0, bcount};
    end

endmodule

// File: rtl/cfi_geom_engine.sv
module cfi_geom_engine
    import cfi_geom_pkg::*;
#(
    parameter int CHIP_W  = 16,
    parameter int IL      = 1,
    parameter int BUS_AW  = 24,
    parameter int MAX_RGN = 32,
    localparam int CNT_W  = $clog2(MAX_RGN + 1),
    localparam int IDX_W  = $clog2(MAX_RGN),
    localparam int BUS_DW = CHIP_W * IL
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic               qry_fail,
    output logic               rgn_clamped,
    output logic [7:0]         alg_id,
    output logic [31:0]        dev_size,
    output logic [31:0]        wbuf_size,
    output logic [CNT_W-1:0]   rgn_count,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [31:0]        rd_start,
    output logic [31:0]        rd_stop,
    output logic [31:0]        rd_bsize,
    output logic [16:0]        rd_bcount,
    output logic [BUS_AW-1:0]  fl_addr,
    output logic [BUS_DW-1:0]  fl_wdata,
    output logic               fl_we,
    output logic               fl_re,
    input  logic [BUS_DW-1:0]  fl_rdata
);
    phase_t            phase;
    logic [1:0]        sub;
    logic [CNT_W-1:0]  rgn_i;
    logic [CNT_W-1:0]  target;
    logic [23:0]       acc;
    logic [31:0]       run_addr;
    logic [7:0]        ofs;
    logic [7:0]        fbyte;
    logic              fvld;
    logic [31:0]       desc_full;
    region_t           calc;
    region_t           tbl [MAX_RGN];
    region_t           rd_ent;

    cfi_byte_fetch #(.CHIP_W(CHIP_W), .IL(IL), .BUS_AW(BUS_AW)) fetch_i (
        .clk(clk), .rst(rst), .req(busy), .ofs(ofs),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re),
        .fl_rdata(fl_rdata), .byte_o(fbyte), .byte_vld(fvld)
    );

    assign desc_full = {fbyte, acc};

    cfi_region_calc #(.IL(IL)) calc_i (
        .desc(desc_full), .base(run_addr), .rgn(calc)
    );

    always_comb begin
        unique case (phase)
            PH_SIG:  ofs = OFS_SIG + 8'(sub);
            PH_ALG:  ofs = OFS_ALG;
            PH_DSZ:  ofs = OFS_DSZ;
            PH_WBS:  ofs = OFS_WBS;
            PH_NRG:  ofs = OFS_NRG;
            default: ofs = 8'(32'(OFS_RGN0) + 32'(rgn_i) * 4 + 32'(sub));
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy        <= 1'b0;
            done        <= 1'b0;
            qry_fail    <= 1'b0;
            rgn_clamped <= 1'b0;
            alg_id      <= '0;
            dev_size    <= '0;
            wbuf_size   <= '0;
            rgn_count   <= '0;
            phase       <= PH_SIG;
            sub         <= '0;
            rgn_i       <= '0;
            target      <= '0;
            acc         <= '0;
            run_addr    <= '0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy        <= 1'b1;
                qry_fail    <= 1'b0;
                rgn_clamped <= 1'b0;
                alg_id      <= '0;
                dev_size    <= '0;
                wbuf_size   <= '0;
                rgn_count   <= '0;
                phase       <= PH_SIG;
                sub         <= '0;
                rgn_i       <= '0;
                target      <= '0;
                run_addr    <= '0;
            end else if (busy && fvld) begin
                unique case (phase)
                    PH_SIG: begin
                        if (fbyte != sig_byte(sub)) begin
                            qry_fail <= 1'b1;
                            busy     <= 1'b0;
                            done     <= 1'b1;
                        end else if (sub == 2'd2) begin
                            sub   <= '0;
                            phase <= PH_ALG;
                        end else begin
                            sub <= sub + 2'd1;
                        end
                    end
                    PH_ALG: begin
                        alg_id <= fbyte;
                        phase  <= PH_DSZ;
                    end
                    PH_DSZ: begin
                        dev_size <= 32'(IL) << fbyte;
                        phase    <= PH_WBS;
                    end
                    PH_WBS: begin
                        wbuf_size <= 32'(IL) << fbyte;
                        phase     <= PH_NRG;
                    end
                    PH_NRG: begin
                        if (32'(fbyte) > 32'(MAX_RGN)) begin
                            target      <= CNT_W'(MAX_RGN);
                            rgn_clamped <= 1'b1;
                        end else begin
                            target <= CNT_W'(fbyte);
                        end
                        if (fbyte == 8'd0) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end else begin
                            phase <= PH_RGN;
                            sub   <= '0;
                            rgn_i <= '0;
                        end
                    end
                    default: begin
                        if (sub == 2'd3) begin
                            sub      <= '0;
                            run_addr <= calc.stop;
                            if (rgn_i + CNT_W'(1) == target) begin
                                rgn_count <= target;
                                busy      <= 1'b0;
                                done      <= 1'b1;
                            end else begin
                                rgn_i <= rgn_i + CNT_W'(1);
                            end
                        end else begin
                            acc[8*sub +: 8] <= fbyte;
                            sub             <= sub + 2'd1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (busy && fvld && phase == PH_RGN && sub == 2'd3)
            tbl[rgn_i[IDX_W-1:0]] <= calc;
    end

    always_comb begin
        if (CNT_W'(rd_idx) < rgn_count) rd_ent = tbl[rd_idx];
        else                            rd_ent = '0;
        rd_start  = rd_ent.start;
        rd_stop   = rd_ent.stop;
        rd_bsize  = rd_ent.bsize;
        rd_bcount = rd_ent.bcount;
    end

endmodule

// File: rtl/cfi_geom_checker.sv
module cfi_geom_checker #(
    parameter int MAX_RGN = 32,
    parameter int CNT_W   = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic             done,
    input logic             qry_fail,
    input logic             rgn_clamped,
    input logic [CNT_W-1:0] rgn_count,
    input logic             fl_we,
    input logic             fl_re
);
    assert_we_re_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(fl_we && fl_re));

    assert_enter_before_read_R2: assert property (@(posedge clk) disable iff (rst)
        fl_re |-> $past(fl_we));

    assert_exit_after_read_R2: assert property (@(posedge clk) disable iff (rst)
        fl_re |-> ##2 fl_we);

    assert_fail_empty_R4: assert property (@(posedge clk) disable iff (rst)
        (done && qry_fail) |-> (rgn_count == '0) && !rgn_clamped);

    assert_cnt_cap_R7: assert property (@(posedge clk) disable iff (rst)
        32'(rgn_count) <= MAX_RGN);

    assert_clamp_full_R7: assert property (@(posedge clk) disable iff (rst)
        (done && rgn_clamped) |-> (32'(rgn_count) == MAX_RGN));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && $past(busy));

    assert_bus_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (fl_we || fl_re) |-> busy);

endmodule

bind cfi_geom_engine cfi_geom_checker #(.MAX_RGN(MAX_RGN), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .qry_fail(qry_fail),
    .rgn_clamped(rgn_clamped), .rgn_count(rgn_count), .fl_we(fl_we), .fl_re(fl_re)
);

// File: tb/cfi_geom_engine_tb_top.sv
`timescale 1ns/1ps

module cfi_flash_model #(
    parameter int CHIP_W = 16,
    parameter int IL     = 1,
    parameter int AW     = 24
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [AW-1:0]        addr,
    input  logic [CHIP_W*IL-1:0] wdata,
    input  logic                 we,
    input  logic                 re,
    input  logic [7:0]           qtab [256],
    output logic [CHIP_W*IL-1:0] rdata,
    output logic                 in_query,
    output int                   nrd,
    output int                   nwr,
    output int                   nbad
);
    localparam int QA = (CHIP_W == 8) ? 'hAA : 'h55;

    function automatic logic [CHIP_W*IL-1:0] spread(input logic [7:0] b);
        logic [CHIP_W*IL-1:0] v;
        for (int k = 0; k < IL; k++)
            v[k*CHIP_W +: CHIP_W] = (CHIP_W == 8) ? CHIP_W'(b) : CHIP_W'({b, 8'h00});
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            in_query <= 1'b0;
            nrd <= 0; nwr <= 0; nbad <= 0;
            rdata <= '0;
        end else begin
            if (we) begin
                logic [7:0] c;
                c = wdata[CHIP_W-1 -: 8];
                nwr <= nwr + 1;
                if (int'(addr) != QA || wdata != spread(c)) nbad <= nbad + 1;
                else if (c == 8'h98) in_query <= 1'b1;
                else if (c == 8'hFF) in_query <= 1'b0;
                else nbad <= nbad + 1;
            end
            if (re) begin
                int o;
                o = (CHIP_W == 8) ? int'(addr >> 1) : int'(addr);
                nrd <= nrd + 1;
                if (!in_query || o > 255 || (CHIP_W == 8 && addr[0])) begin
                    nbad  <= nbad + 1;
                    rdata <= {(CHIP_W*IL/4){4'hA}};
                end else begin
                    rdata <= spread(qtab[o]);
                end
            end
        end
    end
endmodule

module cfi_geom_engine_tb_top;
    localparam int MAXR  = 4;
    localparam int CNT_W = $clog2(MAXR + 1);
    localparam int IDX_W = $clog2(MAXR);
    localparam int AW    = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [7:0] qtab [256];

    int n_checks = 0;
    int n_errors = 0;

    // 16-bit chip instance (a_) and two interleaved 8-bit chips (b_)
    logic a_busy, a_done, a_fail, a_clamp, a_we, a_re, a_inq;
    logic [7:0] a_alg;
    logic [31:0] a_dsz, a_wbs, a_rs, a_re_a, a_rb;
    logic [16:0] a_rc;
    logic [CNT_W-1:0] a_cnt;
    logic [AW-1:0] a_addr;
    logic [15:0] a_wd, a_rd;
    int a_nrd, a_nwr, a_nbad, a_dones;

    logic b_busy, b_done, b_fail, b_clamp, b_we, b_re, b_inq;
    logic [7:0] b_alg;
    logic [31:0] b_dsz, b_wbs, b_rs, b_re_a, b_rb;
    logic [16:0] b_rc;
    logic [CNT_W-1:0] b_cnt;
    logic [AW-1:0] b_addr;
    logic [15:0] b_wd, b_rd;
    int b_nrd, b_nwr, b_nbad, b_dones;

    always #5 clk = ~clk;

    cfi_geom_engine #(.CHIP_W(16), .IL(1), .BUS_AW(AW), .MAX_RGN(MAXR)) dut_i (
        .clk(clk), .rst(rst), .start(start), .busy(a_busy), .done(a_done),
        .qry_fail(a_fail), .rgn_clamped(a_clamp), .alg_id(a_alg),
        .dev_size(a_dsz), .wbuf_size(a_wbs), .rgn_count(a_cnt), .rd_idx(rd_idx),
        .rd_start(a_rs), .rd_stop(a_re_a), .rd_bsize(a_rb), .rd_bcount(a_rc),
        .fl_addr(a_addr), .fl_wdata(a_wd), .fl_we(a_we), .fl_re(a_re), .fl_rdata(a_rd)
    );
    cfi_flash_model #(.CHIP_W(16), .IL(1), .AW(AW)) mdl_a (
        .clk(clk), .rst(rst), .addr(a_addr), .wdata(a_wd), .we(a_we), .re(a_re),
        .qtab(qtab), .rdata(a_rd), .in_query(a_inq), .nrd(a_nrd), .nwr(a_nwr), .nbad(a_nbad)
    );

    cfi_geom_engine #(.CHIP_W(8), .IL(2), .BUS_AW(AW), .MAX_RGN(MAXR)) dut8_i (
        .clk(clk), .rst(rst), .start(start), .busy(b_busy), .done(b_done),
        .qry_fail(b_fail), .rgn_clamped(b_clamp), .alg_id(b_alg),
        .dev_size(b_dsz), .wbuf_size(b_wbs), .rgn_count(b_cnt), .rd_idx(rd_idx),
        .rd_start(b_rs), .rd_stop(b_re_a), .rd_bsize(b_rb), .rd_bcount(b_rc),
        .fl_addr(b_addr), .fl_wdata(b_wd), .fl_we(b_we), .fl_re(b_re), .fl_rdata(b_rd)
    );
    cfi_flash_model #(.CHIP_W(8), .IL(2), .AW(AW)) mdl_b (
        .clk(clk), .rst(rst), .addr(b_addr), .wdata(b_wd), .we(b_we), .re(b_re),
        .qtab(qtab), .rdata(b_rd), .in_query(b_inq), .nrd(b_nrd), .nwr(b_nwr), .nbad(b_nbad)
    );

    always @(posedge clk) begin
        if (rst) begin a_dones <= 0; b_dones <= 0; end
        else begin
            if (a_done) a_dones <= a_dones + 1;
            if (b_done) b_dones <= b_dones + 1;
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
        end
    endtask

    task automatic run_case(input int n_raw, input int dsz, input int wbs, input int alg,
                            input int hb, input int lb, input int badk, input bit mid_start);
        int nexp, reads, cyc;
        logic [15:0] hi [MAXR];
        logic [15:0] lo [MAXR];
        nexp = (n_raw > MAXR) ? MAXR : n_raw;
        for (int i = 0; i < 256; i++) qtab[i] = 8'h00;
        qtab[8'h10] = 8'h51; qtab[8'h11] = 8'h52; qtab[8'h12] = 8'h59;
        if (badk != 0) qtab[8'h10 + badk - 1] = 8'h58;
        qtab[8'h13] = 8'(alg); qtab[8'h27] = 8'(dsz); qtab[8'h2A] = 8'(wbs);
        qtab[8'h2C] = 8'(n_raw);
        for (int i = 0; i <= MAXR; i++) begin
            logic [15:0] h, l;
            h = 16'(hb + i * 37);
            l = 16'(lb + i * 101);
            if (i < MAXR) begin hi[i] = h; lo[i] = l; end
            qtab[8'h2D + 4*i]     = l[7:0];
            qtab[8'h2D + 4*i + 1] = l[15:8];
            qtab[8'h2D + 4*i + 2] = h[7:0];
            qtab[8'h2D + 4*i + 3] = h[15:8];
        end
        reads = (badk != 0) ? badk : 7 + 4 * nexp;

        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "busy/done", {a_busy, a_done, b_busy, b_done}, 4'b0);
        chk("R1", "strobes", {a_we, a_re, b_we, b_re}, 4'b0);
        chk("R1", "status", {a_fail, a_clamp, a_cnt, b_fail, b_clamp, b_cnt}, '0);
        chk("R1", "geometry", {a_alg, a_dsz, b_wbs}, '0);

        start = 1'b1; @(negedge clk); start = 1'b0;
        cyc = 0;
        while ((a_dones == 0 || b_dones == 0) && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (mid_start && cyc == 12) start = 1'b1;
            if (mid_start && cyc == 13) start = 1'b0;
        end
        if (cyc >= 5000) begin
            n_checks++; n_errors++;
            $display("FAIL R10 watchdog: actual no done expected done");
            return;
        end
        repeat (3) @(negedge clk);

        chk("R10", "done count a", 64'(a_dones), 1);
        chk("R10", "done count b", 64'(b_dones), 1);
        chk("R10", "busy after", {a_busy, b_busy}, 2'b0);
        chk("R2", "reads a", 64'(a_nrd), 64'(reads));
        chk("R2", "reads b", 64'(b_nrd), 64'(reads));
        chk("R2", "writes a", 64'(a_nwr), 64'(2 * reads));
        chk("R2", "writes b", 64'(b_nwr), 64'(2 * reads));
        chk("R2", "array mode at end", {a_inq, b_inq}, 2'b0);
        chk("R3", "protocol errors a", 64'(a_nbad), 0);
        chk("R3", "protocol errors b", 64'(b_nbad), 0);

        if (badk != 0) begin
            chk("R4", "fail flag", {a_fail, b_fail}, 2'b11);
            chk("R4", "no regions", {a_cnt, b_cnt, a_alg, b_alg}, '0);
        end else begin
            chk("R4", "fail flag", {a_fail, b_fail}, 2'b00);
            chk("R5", "alg id a", a_alg, 64'(alg));
            chk("R5", "alg id b", b_alg, 64'(alg));
            chk("R6", "dev size a", a_dsz, 64'(32'(1) << dsz));
            chk("R6", "dev size b", b_dsz, 64'(32'(2) << dsz));
            chk("R6", "wbuf size a", a_wbs, 64'(32'(1) << wbs));
            chk("R6", "wbuf size b", b_wbs, 64'(32'(2) << wbs));
            chk("R7", "count a", 64'(a_cnt), 64'(nexp));
            chk("R7", "count b", 64'(b_cnt), 64'(nexp));
            chk("R7", "clamp flag", {a_clamp, b_clamp}, (n_raw > MAXR) ? 2'b11 : 2'b00);
            for (int il = 1; il <= 2; il++) begin
                logic [31:0] s;
                s = 32'd0;
                for (int i = 0; i < MAXR; i++) begin
                    logic [31:0] bs, bc, e;
                    logic [31:0] g_s, g_e, g_b;
                    logic [16:0] g_c;
                    bs = {8'h00, hi[i], 8'h00} * 32'(il);
                    bc = 32'(lo[i]) + 32'd1;
                    e  = s + bs * bc;
                    rd_idx = IDX_W'(i);
                    #1;
                    g_s = (il == 1) ? a_rs : b_rs;
                    g_e = (il == 1) ? a_re_a : b_re_a;
                    g_b = (il == 1) ? a_rb : b_rb;
                    g_c = (il == 1) ? a_rc : b_rc;
                    if (i < nexp) begin
                        chk("R8", "block size", g_b, bs);
                        chk("R8", "block count", g_c, bc[16:0]);
                        chk("R9", "region start", g_s, s);
                        chk("R9", "region end", g_e, e);
                        s = e;
                    end else begin
                        chk("R11", "empty entry", {g_s, g_e, g_b, 15'd0, g_c}, '0);
                    end
                end
            end
        end
    endtask

    initial begin
        run_case(0, 20, 5, 1, 1, 0, 0, 1'b0);
        for (int n = 1; n <= MAXR; n++)
            run_case(n, 16 + n, 3 + n, n, 2 + n, 7 * n, 0, 1'b0);
        run_case(MAXR + 1, 22, 6, 3, 4, 9, 0, 1'b0);
        run_case(255, 24, 8, 2, 1, 1, 0, 1'b0);
        for (int k = 1; k <= 3; k++)
            run_case(3, 20, 5, 1, 1, 0, k, 1'b0);
        run_case(2, 23, 7, 2, 16'hFFFF, 16'hFFFF, 0, 1'b0);
        run_case(3, 21, 4, 1, 5, 3, 0, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule